// File: doc/BRIEF.md
# Address Window Decoder

This block routes each transaction address to one of several downstream targets. It holds a bank of programmable windows. Each window has an enable, a 4-bit target code, a 4-bit security word and an inclusive address range at 1 MB granularity. A lookup names the upper address bits, the direction and the security level of a transaction. One cycle later the block returns a hit flag and the target of the lowest-numbered window that accepts the transaction. When no window accepts it, the block reports a miss with target 0.

Window 0 is the configuration-space window. It cannot be turned off, and it always spans 16 one-megabyte blocks that start at its low limit. Software can move it at run time by rewriting that low limit. A word-addressed register port programs every window. The security word also guards the register port itself: a window can refuse register writes, register reads, or both, when they come from non-secure software.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, window 0 is enabled with target 0, a zero security word and a low limit equal to the CFG_BASE_BLK parameter. Windows 1 to 15 read back all zero.
- R2: The register port is word addressed: word index = window*8 + slot, with slot 0 = control (bit 0 enable, bits [11:8] target), slot 1 = security, slot 2 = low limit and slot 3 = high limit. A limit register keeps its value in bits [31:4] as address bits [47:20], and its bits [3:0] read as zero. Read data and reg_rvalid appear one cycle after reg_re.
- R3: An enabled window hits when lk_addr (address bits [47:20]) is at or above its low limit and at or below its high limit. out_valid, out_hit and out_target appear one cycle after lk_valid.
- R4: When more than one window hits, the target of the lowest-numbered hitting window is reported.
- R5: When no window hits, out_hit is 0 and out_target is 0.
- R6: Window 0 always hits from its low limit through low limit + 15 blocks. A write that clears its enable bit is ignored, and its high-limit register has no effect on decoding. Its target code remains writable.
- R7: A lookup in the cycle after a write to window 0's low limit uses the new limit. A lookup in the same cycle as that write still uses the old limit.
- R8: Security bit 2 (write secure) makes a non-secure write lookup skip the window. Security bit 3 (read secure) does the same for non-secure read lookups. A skipped window lets a higher-numbered window, or a miss, decide the result.
- R9: Security bit 0 drops non-secure register writes to any register of the window. Security bit 1 makes non-secure register reads of the window return zero.
- R10: A window whose enable bit is 0 never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_secure | input | 1 | Register access comes from secure software |
| reg_addr | input | 7 | Register word index (window*8 + slot) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_re |
| reg_rvalid | output | 1 | reg_rdata is valid |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write transaction |
| lk_secure | input | 1 | Lookup comes from a secure initiator |
| lk_addr | input | 28 | Transaction address bits [47:20] |
| out_valid | output | 1 | Lookup result valid |
| out_hit | output | 1 | A window accepted the lookup |
| out_target | output | 4 | Target code of the winning window, 0 on miss |

## Verification
A register write to window 0's low limit and a lookup can occur in the same cycle. The decode in that cycle must use the old limit, and the decode one cycle later must use the new one. The bench drives the write and a lookup at the new location on the same clock edge, expects a miss, and then repeats the lookup in the next cycle and expects a hit. It also checks that the old location now misses.

// File: rtl/awd_pkg.sv
`timescale 1ns/1ps
package awd_pkg;
  localparam int ADDR_W  = 48;
  localparam int GRAN_SH = 20;
  localparam int LIM_W   = ADDR_W - GRAN_SH;
  localparam int TID_W   = 4;
  localparam int SEC_W   = 4;

  localparam int SEC_CW = 0;  // register write guard
  localparam int SEC_CR = 1;  // register read guard
  localparam int SEC_DW = 2;  // write-lookup guard
  localparam int SEC_DR = 3;  // read-lookup guard

  typedef enum logic [2:0] {
    SLOT_CTRL = 3'd0,
    SLOT_SEC  = 3'd1,
    SLOT_LO   = 3'd2,
    SLOT_HI   = 3'd3
  } slot_e;

  typedef struct packed {
    logic             en;
    logic [TID_W-1:0] tid;
    logic [SEC_W-1:0] sec;
    logic [LIM_W-1:0] lo;
    logic [LIM_W-1:0] hi;
  } win_cfg_t;
endpackage

// File: rtl/awd_regfile.sv
`timescale 1ns/1ps
module awd_regfile
  import awd_pkg::*;
#(
  parameter int               NUM_WIN      = 16,
  parameter logic [LIM_W-1:0] CFG_BASE_BLK = 28'h0000F20,
  localparam int              IDX_W        = $clog2(NUM_WIN),
  localparam int              RA_W         = IDX_W + 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic            reg_secure,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            reg_rvalid,
  output win_cfg_t        cfg [NUM_WIN]
);
  logic [IDX_W-1:0] widx;
  slot_e            slot;
  logic [SEC_W-1:0] acc_sec;
  logic             wr_ok, rd_ok;
  logic [31:0]      rd_word;

  assign widx    = reg_addr[RA_W-1:3];
  assign slot    = slot_e'(reg_addr[2:0]);
  assign acc_sec = cfg[widx].sec;
  assign wr_ok   = reg_secure || !acc_sec[SEC_CW];
  assign rd_ok   = reg_secure || !acc_sec[SEC_CR];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[i].en  <= (i == 0);
        cfg[i].tid <= '0;
        cfg[i].sec <= '0;
        cfg[i].lo  <= (i == 0) ? CFG_BASE_BLK : '0;
        cfg[i].hi  <= '0;
      end else if (reg_we && wr_ok && widx == IDX_W'(i)) begin
        case (slot)
          SLOT_CTRL: begin
            cfg[i].en  <= (i == 0) ? 1'b1 : reg_wdata[0];
            cfg[i].tid <= reg_wdata[8 +: TID_W];
          end
          SLOT_SEC: cfg[i].sec <= reg_wdata[SEC_W-1:0];
          SLOT_LO:  cfg[i].lo  <= reg_wdata[31:4];
          SLOT_HI:  cfg[i].hi  <= reg_wdata[31:4];
          default: ;
        endcase
      end
    end

    // R9: a guarded window keeps every field across a non-secure write
    assert_locked_window_stable_R9: assert property (@(posedge clk) disable iff (rst)
      (reg_we && !reg_secure && cfg[i].sec[SEC_CW] && widx == IDX_W'(i)) |=> $stable(cfg[i]));
  end

  always_comb begin
    rd_word = '0;
    case (slot)
      SLOT_CTRL: begin
        rd_word[0]          = cfg[widx].en;
        rd_word[8 +: TID_W] = cfg[widx].tid;
      end
      SLOT_SEC: rd_word[SEC_W-1:0] = cfg[widx].sec;
      SLOT_LO:  rd_word[31:4]      = cfg[widx].lo;
      SLOT_HI:  rd_word[31:4]      = cfg[widx].hi;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_re;
      if (reg_re) reg_rdata <= rd_ok ? rd_word : 32'h0;
    end
  end

  assert_read_returns_R2: assert property (@(posedge clk) disable iff (rst)
    reg_re |=> reg_rvalid);
  assert_cfg_window_on_R6: assert property (@(posedge clk) disable iff (rst)
    cfg[0].en);
endmodule

// File: rtl/awd_match.sv
`timescale 1ns/1ps
module awd_match
  import awd_pkg::*;
(
  input  logic             en,
  input  logic             rd_guard,
  input  logic             wr_guard,
  input  logic [LIM_W-1:0] lo,
  input  logic [LIM_W:0]   hi_ext,
  input  logic [LIM_W-1:0] blk,
  input  logic             is_write,
  input  logic             secure,
  output logic             hit
);
  logic in_range, blocked;
  assign in_range = (blk >= lo) && ({1'b0, blk} <= hi_ext);
  assign blocked  = !secure && (is_write ? wr_guard : rd_guard);
  assign hit      = en && in_range && !blocked;
endmodule

// File: rtl/awd_select.sv
`timescale 1ns/1ps
module awd_select
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 16
) (
  input  logic [NUM_WIN-1:0] hits,
  input  logic [TID_W-1:0]   tids [NUM_WIN],
  output logic               any,
  output logic [TID_W-1:0]   tid
);
  always_comb begin
    any = 1'b0;
    tid = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        tid = tids[i];
      end
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
`timescale 1ns/1ps
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int               NUM_WIN      = 16,
  parameter int               CFG_BLKS     = 16,
  parameter logic [LIM_W-1:0] CFG_BASE_BLK = 28'h0000F20,
  localparam int              RA_W         = $clog2(NUM_WIN) + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic                    reg_re,
  input  logic                    reg_secure,
  input  logic [RA_W-1:0]         reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    reg_rvalid,
  input  logic                    lk_valid,
  input  logic                    lk_write,
  input  logic                    lk_secure,
  input  logic [ADDR_W-1:GRAN_SH] lk_addr,
  output logic                    out_valid,
  output logic                    out_hit,
  output logic [TID_W-1:0]        out_target
);
  win_cfg_t           cfg [NUM_WIN];
  logic [NUM_WIN-1:0] hits;
  logic [TID_W-1:0]   tids [NUM_WIN];
  logic               any_hit;
  logic [TID_W-1:0]   win_tid;

  awd_regfile #(.NUM_WIN(NUM_WIN), .CFG_BASE_BLK(CFG_BASE_BLK)) i_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_secure(reg_secure), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .cfg(cfg)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    logic [LIM_W:0] hi_ext;
    if (g == 0) begin : g_fixed
      assign hi_ext = {1'b0, cfg[g].lo} + (LIM_W+1)'(CFG_BLKS - 1);
    end else begin : g_prog
      assign hi_ext = {1'b0, cfg[g].hi};
    end
    assign tids[g] = cfg[g].tid;
    awd_match i_match (
      .en(cfg[g].en), .rd_guard(cfg[g].sec[SEC_DR]), .wr_guard(cfg[g].sec[SEC_DW]),
      .lo(cfg[g].lo), .hi_ext(hi_ext), .blk(lk_addr),
      .is_write(lk_write), .secure(lk_secure), .hit(hits[g])
    );
  end

  awd_select #(.NUM_WIN(NUM_WIN)) i_sel (
    .hits(hits), .tids(tids), .any(any_hit), .tid(win_tid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_target <= '0;
    end else begin
      out_valid  <= lk_valid;
      out_hit    <= lk_valid && any_hit;
      out_target <= (lk_valid && any_hit) ? win_tid : '0;
    end
  end

  assert_result_follows_req_R3: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> out_valid);
  assert_idle_no_hit_R3: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_hit);
  assert_miss_target_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_hit) |-> (out_target == '0));
endmodule

// File: tb/test_addr_window_decoder.sv
`timescale 1ns/1ps
module test_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 0, reg_re = 0, reg_secure = 0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        lk_valid = 0, lk_write = 0, lk_secure = 0;
  logic [47:20] lk_addr = '0;
  logic        out_valid, out_hit;
  logic [3:0]  out_target;

  int checks = 0;
  int fails  = 0;
  localparam logic [27:0] BASE = 28'h0000F20;

  always #4 clk = ~clk;

  addr_window_decoder i_addr_window_decoder (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_secure(reg_secure),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_secure(lk_secure), .lk_addr(lk_addr), .out_valid(out_valid),
    .out_hit(out_hit), .out_target(out_target)
  );

  function automatic logic [6:0] ra(input int w, input int s);
    return 7'(w * 8 + s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int w, input int s, input logic [31:0] d, input logic sec);
    @(negedge clk);
    reg_we = 1; reg_addr = ra(w, s); reg_wdata = d; reg_secure = sec;
    @(negedge clk);
    reg_we = 0; reg_secure = 0;
  endtask

  task automatic rd_check(input string req, input int w, input int s, input logic sec,
                          input logic [31:0] exp);
    @(negedge clk);
    reg_re = 1; reg_addr = ra(w, s); reg_secure = sec;
    @(negedge clk);
    reg_re = 0; reg_secure = 0;
    check({req, " rvalid"}, {31'b0, reg_rvalid}, 32'd1);
    check(req, reg_rdata, exp);
  endtask

  task automatic lk_check(input string req, input logic [27:0] blk, input logic wrt,
                          input logic sec, input logic exp_hit, input logic [3:0] exp_tid);
    @(negedge clk);
    lk_valid = 1; lk_addr = blk; lk_write = wrt; lk_secure = sec;
    @(negedge clk);
    lk_valid = 0;
    check({req, " valid"}, {31'b0, out_valid}, 32'd1);
    check({req, " hit"}, {31'b0, out_hit}, {31'b0, exp_hit});
    check({req, " target"}, {28'b0, out_target}, {28'b0, exp_tid});
  endtask

  task automatic t_reset;
    rd_check("R1 win0 ctrl", 0, 0, 0, 32'h1);
    rd_check("R1 win0 lo", 0, 2, 0, {BASE, 4'h0});
    rd_check("R1 win0 sec", 0, 1, 0, 32'h0);
    rd_check("R1 win5 ctrl", 5, 0, 0, 32'h0);
    rd_check("R1 win15 lo", 15, 2, 0, 32'h0);
  endtask

  task automatic t_program;
    wr(1, 2, 32'h0000100F, 0);
    wr(1, 3, 32'h00001FF0, 0);
    wr(1, 0, 32'h00000201, 0);
    rd_check("R2 lo low bits zero", 1, 2, 0, 32'h00001000);
    rd_check("R2 ctrl layout", 1, 0, 0, 32'h00000201);
    rd_check("R2 hi", 1, 3, 0, 32'h00001FF0);
  endtask

  task automatic t_range;
    lk_check("R3 low bound", 28'h100, 0, 0, 1, 4'd2);
    lk_check("R3 high bound", 28'h1FF, 1, 0, 1, 4'd2);
    lk_check("R5 above", 28'h200, 0, 0, 0, 4'd0);
    lk_check("R5 below", 28'h0FF, 0, 0, 0, 4'd0);
  endtask

  task automatic t_priority;
    wr(2, 2, 32'h00001800, 0);
    wr(2, 3, 32'h00002FF0, 0);
    wr(2, 0, 32'h00000301, 0);
    lk_check("R4 overlap low wins", 28'h180, 0, 0, 1, 4'd2);
    lk_check("R4 only win2", 28'h250, 0, 0, 1, 4'd3);
  endtask

  task automatic t_cfg_window;
    lk_check("R6 cfg start", BASE, 0, 0, 1, 4'd0);
    lk_check("R6 cfg last", BASE + 28'd15, 0, 0, 1, 4'd0);
    lk_check("R6 cfg past end", BASE + 28'd16, 0, 0, 0, 4'd0);
    wr(0, 3, 32'hFFFFFFF0, 0);
    lk_check("R6 hi ignored", BASE + 28'd16, 0, 0, 0, 4'd0);
    wr(0, 0, 32'h00000500, 0);
    rd_check("R6 enable kept", 0, 0, 0, 32'h00000501);
    lk_check("R6 still hits", BASE, 0, 0, 1, 4'd5);
  endtask

  task automatic t_relocate;
    @(negedge clk);
    reg_we = 1; reg_addr = ra(0, 2); reg_wdata = 32'h00008000;
    lk_valid = 1; lk_addr = 28'h800; lk_write = 0; lk_secure = 0;
    @(negedge clk);
    reg_we = 0; lk_valid = 0;
    check("R7 same cycle uses old", {31'b0, out_hit}, 32'd0);
    lk_check("R7 next cycle new", 28'h800, 0, 0, 1, 4'd5);
    lk_check("R7 old base gone", BASE, 0, 0, 0, 4'd0);
  endtask

  task automatic t_data_sec;
    wr(1, 1, 32'h00000008, 0);
    lk_check("R8 ns read blocked", 28'h150, 0, 0, 0, 4'd0);
    lk_check("R8 secure read ok", 28'h150, 0, 1, 1, 4'd2);
    lk_check("R8 ns write ok", 28'h150, 1, 0, 1, 4'd2);
    lk_check("R8 fall through", 28'h190, 0, 0, 1, 4'd3);
    wr(2, 1, 32'h00000004, 0);
    lk_check("R8 ns write blocked", 28'h250, 1, 0, 0, 4'd0);
  endtask

  task automatic t_reg_sec;
    wr(3, 1, 32'h00000003, 1);
    wr(3, 0, 32'h00000401, 0);
    rd_check("R9 ns write dropped", 3, 0, 1, 32'h0);
    rd_check("R9 ns read zero", 3, 1, 0, 32'h0);
    rd_check("R9 secure read", 3, 1, 1, 32'h3);
  endtask

  task automatic t_disable;
    lk_check("R10 before disable", 28'h120, 0, 1, 1, 4'd2);
    wr(1, 0, 32'h00000200, 0);
    lk_check("R10 disabled miss", 28'h120, 0, 1, 0, 4'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_program();
    t_range();
    t_priority();
    t_cfg_window();
    t_relocate();
    t_data_sec();
    t_reg_sec();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule